// File: doc/BRIEF.md
# Constant On-Time Gate Pulse Timer

This block sets the length of each gate-on interval in a switching power stage run with constant on-time control. A start strobe turns the gate on and, in the same edge, clears a digital ramp and an on-time counter. The ramp then rises by a fixed step every clock, which stands in for an analog ramp of fixed slope. The pulse normally ends on the first clock where the ramp has reached the loop's demand code. That ending is held back until a minimum on-time has elapsed. The minimum is supplied as a code, because it follows a sampled line-related quantity.

Three other causes can end a pulse. A hard ceiling on the number of gate-on cycles stops it. A peak-current comparator flag ends it in the same cycle, but this flag is not looked at during a blanking window just after turn-on. A disable input forces the gate off at once. Each time a pulse ends, the block raises a one-cycle end strobe and records a 2-bit code saying why the pulse ended. The code stays held until the next pulse ends.

Top module: `cot_gate_timer`

## Requirements
- R1: After reset, `gateOn` and `endStrobe` are 0 and `endReason` is 2'b00.
- R2: When `gateOn` is 0, `forceOff` is 0 and `startPulse` is 1 at a rising edge, `gateOn` is 1 after that edge. The ramp and the on-time count k start at 0 in the first gate-on cycle.
- R3: In gate-on cycle k the ramp equals k*RAMP_STEP, saturating at all ones. When this value is at or above `demandCode`, the pulse ends after that cycle with reason 2'b00. The gate is then high for k+1 cycles.
- R4: The ramp ending of R3 is only taken in a cycle with k >= `minOnCode`. The gate is therefore high for at least minOnCode+1 cycles when no other cause ends it.
- R5: The gate is never high for more than MAX_ON_CYC consecutive cycles. A pulse cut by this ceiling reports reason 2'b10. When the ramp ending and the ceiling fall on the same cycle, the ramp ending (2'b00) wins.
- R6: If `curLimit` is 1 in a gate-on cycle k >= BLANK_CYC, the pulse ends after that cycle with reason 2'b01. This takes priority over the ramp ending, the minimum on-time and the ceiling.
- R7: `curLimit` has no effect in gate-on cycles with k < BLANK_CYC.
- R8: `forceOff` at 1 in a gate-on cycle ends the pulse after that cycle with reason 2'b11, above every other cause. While `forceOff` is 1, a start is not accepted.
- R9: A `startPulse` that arrives while `gateOn` is 1 is ignored. This holds in the cycle the pulse ends as well, so the gate is still low one cycle after that end.
- R10: `endStrobe` is 1 for exactly the one cycle in which `gateOn` first reads 0 after a pulse. `endReason` changes only at that point and holds its value until the next end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Request to begin a gate pulse |
| forceOff | input | 1 | Disable: ends any pulse and blocks starts |
| curLimit | input | 1 | Peak-current comparator flag |
| demandCode | input | RAMP_W | Loop demand the ramp is compared against |
| minOnCode | input | TIME_W | Minimum on-time in clock cycles |
| gateOn | output | 1 | Gate drive |
| endStrobe | output | 1 | One-cycle marker of a pulse end |
| endReason | output | 2 | Cause of the last end: 00 ramp, 01 current limit, 10 ceiling, 11 forced |

## Verification
The bench builds the timer with a 200-cycle ceiling, an 8-cycle blanking window, a ramp step of 3, an 8-bit time code and a 10-bit demand code. With these values a ceiling-limited pulse lasts only 200 cycles, so many such pulses fit in one run. A demand of 597 lands the ramp hit exactly on the ceiling cycle, which exercises the tie rule. Minimum-on codes above the ceiling can also be driven. The blanking edge is a few cycles from turn-on, so random current-limit onsets fall on both sides of it.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [1:0] {
    END_RAMP   = 2'b00,
    END_ILIM   = 2'b01,
    END_TMAX   = 2'b10,
    END_FORCED = 2'b11
  } endCause_e;

  // control -> datapath
  typedef struct packed {
    logic clearCnt;
    logic advance;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic blankDone;
    logic minDone;
    logic rampHit;
    logic maxHit;
  } dpFlags_t;
endpackage

// File: rtl/cot_datapath.sv
module cot_datapath #(
  parameter int TIME_W     = 12,
  parameter int RAMP_W     = 14,
  parameter int RAMP_STEP  = 5,
  parameter int BLANK_CYC  = 20,
  parameter int MAX_ON_CYC = 3250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cot_pkg::dpStrobe_t   strobe,
  input  logic [RAMP_W-1:0]    demandCode,
  input  logic [TIME_W-1:0]    minOnCode,
  output cot_pkg::dpFlags_t    flags
);
  localparam logic [TIME_W-1:0] BLANK_LIM = TIME_W'(BLANK_CYC);
  localparam logic [TIME_W-1:0] LAST_CYC  = TIME_W'(MAX_ON_CYC - 1);
  localparam logic [RAMP_W:0]   STEP_EXT  = (RAMP_W+1)'(RAMP_STEP);

  logic [TIME_W-1:0] onCnt;
  logic [RAMP_W-1:0] ramp;
  logic [RAMP_W:0]   rampSum;

  assign rampSum = {1'b0, ramp} + STEP_EXT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onCnt <= '0;
      ramp  <= '0;
    end else if (strobe.clearCnt) begin
      onCnt <= '0;
      ramp  <= '0;
    end else if (strobe.advance) begin
      if (onCnt != {TIME_W{1'b1}}) onCnt <= onCnt + 1'b1;
      ramp <= rampSum[RAMP_W] ? {RAMP_W{1'b1}} : rampSum[RAMP_W-1:0];
    end
  end

  always_comb begin
    flags.blankDone = (onCnt >= BLANK_LIM);
    flags.minDone   = (onCnt >= minOnCode);
    flags.rampHit   = (ramp >= demandCode);
    flags.maxHit    = (onCnt >= LAST_CYC);
  end

  // R5: while the gate is on, the count never passes the ceiling
  a_r5_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |-> (onCnt <= LAST_CYC));

  // R3: the ramp never falls during a pulse
  a_r3_ramp_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !strobe.clearCnt) |=> (ramp >= $past(ramp)));
endmodule

// File: rtl/cot_ctrl.sv
module cot_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startPulse,
  input  logic                forceOff,
  input  logic                curLimit,
  input  cot_pkg::dpFlags_t   flags,
  output cot_pkg::dpStrobe_t  strobe,
  output logic                gateOn,
  output logic                endStrobe,
  output cot_pkg::endCause_e  endReason
);
  import cot_pkg::*;

  logic      endNow;
  logic      startOk;
  endCause_e cause;

  // priority: forced, current limit, ramp, ceiling
  always_comb begin
    endNow = 1'b0;
    cause  = END_RAMP;
    if (forceOff) begin
      endNow = 1'b1;
      cause  = END_FORCED;
    end else if (curLimit && flags.blankDone) begin
      endNow = 1'b1;
      cause  = END_ILIM;
    end else if (flags.rampHit && flags.minDone) begin
      endNow = 1'b1;
      cause  = END_RAMP;
    end else if (flags.maxHit) begin
      endNow = 1'b1;
      cause  = END_TMAX;
    end
  end

  assign startOk         = !gateOn && startPulse && !forceOff;
  assign strobe.clearCnt = startOk;
  assign strobe.advance  = gateOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateOn    <= 1'b0;
      endStrobe <= 1'b0;
      endReason <= END_RAMP;
    end else begin
      endStrobe <= gateOn && endNow;
      if (startOk) begin
        gateOn <= 1'b1;
      end else if (gateOn && endNow) begin
        gateOn    <= 1'b0;
        endReason <= cause;
      end
    end
  end

  // R2: a rising gate always follows an accepted start
  a_r2_rise_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateOn) |-> ($past(startPulse) && !$past(forceOff)));

  // R10: the end strobe marks the falling gate
  a_r10_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    endStrobe |-> $fell(gateOn));

  // R8: disable while on turns the gate off with the forced code
  a_r8_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOn && forceOff) |=> (!gateOn && endReason == END_FORCED));

  // R6: a current-limit ending needs the comparator flag
  a_r6_limit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (endStrobe && endReason == END_ILIM) |-> $past(curLimit));
endmodule

// File: rtl/cot_gate_timer.sv
module cot_gate_timer #(
  parameter int TIME_W     = 12,
  parameter int RAMP_W     = 14,
  parameter int RAMP_STEP  = 5,
  parameter int BLANK_CYC  = 20,
  parameter int MAX_ON_CYC = 3250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPulse,
  input  logic              forceOff,
  input  logic              curLimit,
  input  logic [RAMP_W-1:0] demandCode,
  input  logic [TIME_W-1:0] minOnCode,
  output logic              gateOn,
  output logic              endStrobe,
  output logic [1:0]        endReason
);
  cot_pkg::dpStrobe_t strobe;
  cot_pkg::dpFlags_t  flags;
  cot_pkg::endCause_e reasonQ;

  cot_datapath #(
    .TIME_W(TIME_W), .RAMP_W(RAMP_W), .RAMP_STEP(RAMP_STEP),
    .BLANK_CYC(BLANK_CYC), .MAX_ON_CYC(MAX_ON_CYC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .demandCode(demandCode), .minOnCode(minOnCode), .flags(flags)
  );

  cot_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .forceOff(forceOff),
    .curLimit(curLimit), .flags(flags), .strobe(strobe),
    .gateOn(gateOn), .endStrobe(endStrobe), .endReason(reasonQ)
  );

  assign endReason = reasonQ;
endmodule

// File: tb/cot_gate_timer_bench.sv
module cot_gate_timer_bench;
  localparam int TIME_W = 8, RAMP_W = 10, STEP = 3, BLANK = 8, MAXON = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic startPulse = 1'b0, forceOff = 1'b0, curLimit = 1'b0;
  logic [RAMP_W-1:0] demandCode = '0;
  logic [TIME_W-1:0] minOnCode = '0;
  logic gateOn, endStrobe;
  logic [1:0] endReason;

  int nChecks = 0, nFails = 0, cycles = 0;

  always #10 clk = ~clk;

  cot_gate_timer #(.TIME_W(TIME_W), .RAMP_W(RAMP_W), .RAMP_STEP(STEP),
                   .BLANK_CYC(BLANK), .MAX_ON_CYC(MAXON)) u_cot_gate_timer (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .forceOff(forceOff),
    .curLimit(curLimit), .demandCode(demandCode), .minOnCode(minOnCode),
    .gateOn(gateOn), .endStrobe(endStrobe), .endReason(endReason));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  // reference model from the requirements: width and cause of one pulse
  task automatic model(input int d, input int mn, input int clAt, input int fAt,
                       output int w, output int rsn);
    w = 0; rsn = 0;
    for (int k = 0; k < 1000; k++) begin
      if (fAt >= 0 && k == fAt) begin w = k + 1; rsn = 3; return; end
      if (clAt >= 0 && k >= clAt && k >= BLANK) begin w = k + 1; rsn = 1; return; end
      if (k * STEP >= d && k >= mn) begin w = k + 1; rsn = 0; return; end
      if (k >= MAXON - 1) begin w = k + 1; rsn = 2; return; end
    end
  endtask

  function automatic string tagFor(input int rsn, input int d, input int mn, input int clAt);
    int need;
    need = (d + STEP - 1) / STEP;
    case (rsn)
      3: return "R8";
      2: return "R5";
      1: return (clAt < BLANK) ? "R7" : "R6";
      default: return (mn > need) ? "R4" : "R3";
    endcase
  endfunction

  task automatic runPulse(input int d, input int mn, input int clAt, input int fAt,
                          input bit junk);
    int w, expW, expR;
    string tag;
    model(d, mn, clAt, fAt, expW, expR);
    tag = tagFor(expR, d, mn, clAt);
    @(negedge clk);
    demandCode = RAMP_W'(d); minOnCode = TIME_W'(mn);
    curLimit = 1'b0; forceOff = 1'b0; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(gateOn === 1'b1, "R2", "gate after start", int'(gateOn), 1);
    w = 0;
    while (gateOn && w < 1000) begin
      curLimit   = (clAt >= 0 && w >= clAt);
      forceOff   = (fAt >= 0 && w == fAt);
      startPulse = junk ? 1'($urandom_range(0, 1)) : 1'b0;
      w++;
      @(negedge clk);
    end
    chk(w == expW, tag, "gate width", w, expW);
    chk(int'(endReason) == expR, tag, "end reason", int'(endReason), expR);
    chk(endStrobe === 1'b1, "R10", "strobe at fall", int'(endStrobe), 1);
    curLimit = 1'b0; forceOff = 1'b0; startPulse = 1'b0;
    @(negedge clk);
    chk(gateOn === 1'b0, "R9", "no restart from start while on", int'(gateOn), 0);
    chk(endStrobe === 1'b0, "R10", "strobe one cycle", int'(endStrobe), 0);
    chk(int'(endReason) == expR, "R10", "reason held", int'(endReason), expR);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(gateOn === 1'b0, "R1", "gate in reset", int'(gateOn), 0);
    chk(endStrobe === 1'b0, "R1", "strobe in reset", int'(endStrobe), 0);
    chk(endReason === 2'b00, "R1", "reason in reset", int'(endReason), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gateOn === 1'b0, "R1", "gate after reset", int'(gateOn), 0);

    // R8: start refused while disabled
    forceOff = 1'b1; startPulse = 1'b1;
    @(negedge clk);
    chk(gateOn === 1'b0, "R8", "start while disabled", int'(gateOn), 0);
    forceOff = 1'b0; startPulse = 1'b0;

    runPulse(0, 0, -1, -1, 0);     // R3 single cycle
    runPulse(30, 0, -1, -1, 0);    // R3 ramp hit at k=10
    runPulse(30, 20, -1, -1, 0);   // R4 minimum dominates
    runPulse(1000, 0, -1, -1, 0);  // R5 ceiling
    runPulse(597, 0, -1, -1, 0);   // R5 tie: ramp wins on last cycle
    runPulse(0, 250, -1, -1, 0);   // R5 min beyond ceiling
    runPulse(600, 0, 3, -1, 0);    // R7 limit held from blanking
    runPulse(30, 0, 12, -1, 0);    // R6 ramp comes first
    runPulse(30, 0, 10, -1, 0);    // R6 same cycle as ramp
    runPulse(0, 20, 9, -1, 0);     // R6 over minimum
    runPulse(600, 0, 0, 4, 0);     // R8 forced inside blanking
    runPulse(600, 0, 9, 9, 1);     // R8 over limit, R9 junk starts

    for (int i = 0; i < 60; i++) begin
      int d, mn, clAt, fAt;
      d    = $urandom_range(0, 700);
      mn   = $urandom_range(0, 60);
      clAt = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 150)) : -1;
      fAt  = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 150)) : -1;
      runPulse(d, mn, clAt, fAt, 1);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule